// File: doc/BRIEF.md
# Fan Tachometer Timer Register Interface

This block is the register front end of a two-channel fan tachometer timer. It decodes a single-cycle synchronous bus that addresses bytes, and it holds the configuration that the capture channels consume: the prescaler, the clock select, the mode control, the two compare values, the compare configuration and the two input selects. Each register accepts only its own access width. A wrong width, an odd offset or an unmapped offset raises an error flag, returns zero data and leaves all state unchanged.

The channels report capture, underflow and compare-hit events as one-cycle pulses. The block records these events in a six-bit pending register. Software clears pending bits through a separate write-only clear register, where writing a 1 clears that bit. A single level interrupt is raised while any pending bit is also enabled. The two live counter values and the two capture values belong to the channels. This block only places them on the read path.

Top module: `tach_regif`

## Requirements
- R1: While reset is asserted, every configuration register, the interrupt enable and the pending bits are zero and `irq` is low. The counter and capture offsets still read the live inputs during and after reset.
- R2: The byte registers are read and written with `bus_half`=0, and their data sits in bits [7:0]. The offsets are: prescaler 0x08, clock select 0x0A, mode 0x0C, pending status 0x0E, clear 0x10, interrupt enable 0x12, compare configuration 0x18, input select A 0x1A and input select B 0x1C. The halfword registers are read and written with `bus_half`=1. They are compare A at 0x14 and compare B at 0x16. Multi-byte data is little-endian, so bits [7:0] hold the byte at the offset itself. A written value reads back unchanged and appears on its `cfg_*` output.
- R3: An access to a mapped register with the wrong width sets `bus_err`, returns `bus_rdata`=0 and changes no register.
- R4: An odd offset, or an offset above 0x1C, is rejected in the same way as in R3.
- R5: Halfword reads at offsets 0x00, 0x02, 0x04 and 0x06 return `cnt_a_in`, `cap_a_in`, `cap_b_in` and `cnt_b_in` in that order. Writes to these offsets are accepted without error and have no effect.
- R6: `evt_set` bit k sets pending bit k. The bit positions are: bit 0 capture A, bit 1 capture B, bit 2 underflow A, bit 3 underflow B, bit 4 compare-hit A and bit 5 compare-hit B. The interrupt enable register uses the same positions. The pending register can be read at 0x0E, and writes to 0x0E are ignored.
- R7: Writing the clear register at 0x10 clears each pending bit whose written bit is 1. Reads of 0x10 return zero.
- R8: If a set event and a clear hit the same bit in the same cycle, the bit ends up set. Other bits in the same clear are still cleared.
- R9: `irq` is high exactly when some pending bit has its enable bit set. It follows the register state without added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_half | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_wdata | input | 16 | Write data, little-endian |
| bus_rdata | output | 16 | Read data, same cycle |
| bus_err | output | 1 | Access rejected |
| cnt_a_in | input | 16 | Live counter, channel A |
| cap_a_in | input | 16 | Capture value, channel A |
| cap_b_in | input | 16 | Capture value, channel B |
| cnt_b_in | input | 16 | Live counter, channel B |
| evt_set | input | 6 | Event pulses, one per pending bit |
| cfg_prescale | output | 8 | Prescaler setting |
| cfg_clk_sel | output | 8 | Clock select setting |
| cfg_mode | output | 8 | Mode control setting |
| cfg_cmp_ctl | output | 8 | Compare configuration |
| cfg_src_a | output | 8 | Input select, channel A |
| cfg_src_b | output | 8 | Input select, channel B |
| cfg_cmp_a | output | 16 | Compare value, channel A |
| cfg_cmp_b | output | 16 | Compare value, channel B |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `evt_set` and the bus inputs change only away from the rising clock edge. They also assume that `bus_rdata` and `bus_err` are looked at only while `bus_req` is high. The set-wins and clear properties compare the pending bits one cycle later against the same cycle's event and clear masks, so they depend on events being single-cycle pulses that are not held by the source. The stimulus drives every input on the falling edge, raises each event for exactly one cycle, and drops `bus_req` between accesses, so it stays inside these assumptions.

// File: rtl/tach_regif_pkg.sv
package tach_regif_pkg;

  localparam int NUM_EVT   = 6;
  localparam int NUM_BYTE  = 7;
  localparam int NUM_HALF  = 2;
  localparam int NUM_RID   = 16;

  // register identifier equals byte offset divided by two
  typedef enum logic [3:0] {
    RID_CNT_A  = 4'd0,
    RID_CAP_A  = 4'd1,
    RID_CAP_B  = 4'd2,
    RID_CNT_B  = 4'd3,
    RID_PRESC  = 4'd4,
    RID_CLKSEL = 4'd5,
    RID_MODE   = 4'd6,
    RID_PEND   = 4'd7,
    RID_CLEAR  = 4'd8,
    RID_ENABLE = 4'd9,
    RID_CMP_A  = 4'd10,
    RID_CMP_B  = 4'd11,
    RID_CMPCTL = 4'd12,
    RID_SRC_A  = 4'd13,
    RID_SRC_B  = 4'd14,
    RID_NONE   = 4'd15
  } reg_id_e;

  // storage slots of the configuration bank
  localparam int BYTE_SLOT_RID [NUM_BYTE] = '{4, 5, 6, 9, 12, 13, 14};
  localparam int HALF_SLOT_RID [NUM_HALF] = '{10, 11};

  function automatic reg_id_e offset_to_rid(input logic [4:0] off);
    if (off[0] || (off[4:1] == 4'hF)) return RID_NONE;
    return reg_id_e'(off[4:1]);
  endfunction

  function automatic logic needs_half(input reg_id_e rid);
    return (rid inside {RID_CNT_A, RID_CAP_A, RID_CAP_B, RID_CNT_B,
                        RID_CMP_A, RID_CMP_B});
  endfunction

  function automatic logic width_ok(input reg_id_e rid, input logic half);
    return (rid != RID_NONE) && (needs_half(rid) == half);
  endfunction

  function automatic logic [NUM_EVT-1:0] pend_next(
      input logic [NUM_EVT-1:0] cur,
      input logic [NUM_EVT-1:0] set,
      input logic [NUM_EVT-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_level(input logic [NUM_EVT-1:0] pend,
                                     input logic [NUM_EVT-1:0] en);
    return |(pend & en);
  endfunction

endpackage

// File: rtl/tach_decode.sv
module tach_decode
  import tach_regif_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              half,
  output reg_id_e           rid,
  output logic              legal,
  output logic              err,
  output logic [NUM_RID-1:0] wr_en
);

  logic hi_zero;

  generate
    if (ADDR_W > 5) begin : g_hi
      assign hi_zero = (addr[ADDR_W-1:5] == '0);
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    rid   = hi_zero ? offset_to_rid(addr[4:0]) : RID_NONE;
    legal = req && width_ok(rid, half);
    err   = req && !legal;
    wr_en = (legal && wr) ? (NUM_RID'(1) << rid) : '0;
  end

endmodule

// File: rtl/tach_cfg_bank.sv
module tach_cfg_bank
  import tach_regif_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_RID-1:0]       wr_en,
  input  logic [15:0]              wdata,
  output logic [NUM_BYTE-1:0][7:0] byte_q,
  output logic [NUM_HALF-1:0][15:0] half_q
);

  genvar g;
  generate
    for (g = 0; g < NUM_BYTE; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        byte_q[g] <= '0;
        else if (wr_en[BYTE_SLOT_RID[g]])  byte_q[g] <= wdata[7:0];
      end
    end
    for (g = 0; g < NUM_HALF; g++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        half_q[g] <= '0;
        else if (wr_en[HALF_SLOT_RID[g]])  half_q[g] <= wdata;
      end
    end
  endgenerate

endmodule

// File: rtl/tach_status.sv
module tach_status
  import tach_regif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set,
  input  logic [NUM_EVT-1:0] clr,
  input  logic [NUM_EVT-1:0] en,
  output logic [NUM_EVT-1:0] pend,
  output logic               irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_next(pend, set, clr);
  end

  assign irq = irq_level(pend, en);

endmodule

// File: rtl/tach_regif.sv
module tach_regif
  import tach_regif_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_half,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_err,
  input  logic [15:0]       cnt_a_in,
  input  logic [15:0]       cap_a_in,
  input  logic [15:0]       cap_b_in,
  input  logic [15:0]       cnt_b_in,
  input  logic [5:0]        evt_set,
  output logic [7:0]        cfg_prescale,
  output logic [7:0]        cfg_clk_sel,
  output logic [7:0]        cfg_mode,
  output logic [7:0]        cfg_cmp_ctl,
  output logic [7:0]        cfg_src_a,
  output logic [7:0]        cfg_src_b,
  output logic [15:0]       cfg_cmp_a,
  output logic [15:0]       cfg_cmp_b,
  output logic              irq
);

  // named internal events, visible to the bound checker
  reg_id_e                   rid;
  logic                      acc_legal;
  logic [NUM_RID-1:0]        wr_en;
  logic [NUM_EVT-1:0]        clr_mask;
  logic [NUM_EVT-1:0]        pend_q;
  logic [7:0]                ien_q;
  logic [NUM_BYTE-1:0][7:0]  byte_q;
  logic [NUM_HALF-1:0][15:0] half_q;

  tach_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req   (bus_req),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .half  (bus_half),
    .rid   (rid),
    .legal (acc_legal),
    .err   (bus_err),
    .wr_en (wr_en)
  );

  tach_cfg_bank u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wdata  (bus_wdata),
    .byte_q (byte_q),
    .half_q (half_q)
  );

  assign cfg_prescale = byte_q[0];
  assign cfg_clk_sel  = byte_q[1];
  assign cfg_mode     = byte_q[2];
  assign ien_q        = byte_q[3];
  assign cfg_cmp_ctl  = byte_q[4];
  assign cfg_src_a    = byte_q[5];
  assign cfg_src_b    = byte_q[6];
  assign cfg_cmp_a    = half_q[0];
  assign cfg_cmp_b    = half_q[1];

  assign clr_mask = wr_en[RID_CLEAR] ? bus_wdata[NUM_EVT-1:0] : '0;

  tach_status u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (evt_set),
    .clr   (clr_mask),
    .en    (ien_q[NUM_EVT-1:0]),
    .pend  (pend_q),
    .irq   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc_legal && !bus_wr) begin
      unique case (rid)
        RID_CNT_A:  bus_rdata = cnt_a_in;
        RID_CAP_A:  bus_rdata = cap_a_in;
        RID_CAP_B:  bus_rdata = cap_b_in;
        RID_CNT_B:  bus_rdata = cnt_b_in;
        RID_PRESC:  bus_rdata = {8'h00, byte_q[0]};
        RID_CLKSEL: bus_rdata = {8'h00, byte_q[1]};
        RID_MODE:   bus_rdata = {8'h00, byte_q[2]};
        RID_PEND:   bus_rdata = 16'(pend_q);
        RID_ENABLE: bus_rdata = {8'h00, byte_q[3]};
        RID_CMP_A:  bus_rdata = half_q[0];
        RID_CMP_B:  bus_rdata = half_q[1];
        RID_CMPCTL: bus_rdata = {8'h00, byte_q[4]};
        RID_SRC_A:  bus_rdata = {8'h00, byte_q[5]};
        RID_SRC_B:  bus_rdata = {8'h00, byte_q[6]};
        default:    bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tach_regif_chk.sv
module tach_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_wr,
  input logic        bus_err,
  input logic [15:0] bus_rdata,
  input logic [5:0]  evt_set,
  input logic [5:0]  clr_mask,
  input logic [5:0]  pend_q,
  input logic [7:0]  ien_q,
  input logic [7:0]  cfg_prescale,
  input logic [15:0] cfg_cmp_a,
  input logic        irq
);

  assert_err_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err) |-> (bus_rdata == 16'h0000));

  assert_reject_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_err) |=>
      ($stable(cfg_prescale) && $stable(cfg_cmp_a) && $stable(ien_q)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 6'h00) |=> ((pend_q & $past(evt_set)) == $past(evt_set)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~evt_set) != 6'h00) |=>
      ((pend_q & $past(clr_mask & ~evt_set)) == 6'h00));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q[5:0] == 6'h00) |-> !irq);

  assert_irq_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == 6'h00) |-> !irq);

endmodule

bind tach_regif tach_regif_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_wr       (bus_wr),
  .bus_err      (bus_err),
  .bus_rdata    (bus_rdata),
  .evt_set      (evt_set),
  .clr_mask     (clr_mask),
  .pend_q       (pend_q),
  .ien_q        (ien_q),
  .cfg_prescale (cfg_prescale),
  .cfg_cmp_a    (cfg_cmp_a),
  .irq          (irq)
);

// File: tb/tb_tach_regif.sv
module tb_tach_regif;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [15:0] cnt_a_in = 16'h1111, cap_a_in = 16'h2222;
  logic [15:0] cap_b_in = 16'h3333, cnt_b_in = 16'h4444;
  logic [5:0]  evt_set = '0;
  logic [7:0]  cfg_prescale, cfg_clk_sel, cfg_mode, cfg_cmp_ctl, cfg_src_a, cfg_src_b;
  logic [15:0] cfg_cmp_a, cfg_cmp_b;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tach_regif #(.ADDR_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_half(bus_half), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .cnt_a_in(cnt_a_in), .cap_a_in(cap_a_in), .cap_b_in(cap_b_in),
    .cnt_b_in(cnt_b_in), .evt_set(evt_set),
    .cfg_prescale(cfg_prescale), .cfg_clk_sel(cfg_clk_sel), .cfg_mode(cfg_mode),
    .cfg_cmp_ctl(cfg_cmp_ctl), .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b),
    .cfg_cmp_a(cfg_cmp_a), .cfg_cmp_b(cfg_cmp_b), .irq(irq)
  );

  // {wr, addr, half, wdata, exp_err, exp_rdata}
  localparam int NV = 33;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 5'h08, 1'b0, 16'h00A5, 1'b0, 16'h0000},
    {1'b0, 5'h08, 1'b0, 16'h0000, 1'b0, 16'h00A5},
    {1'b1, 5'h14, 1'b1, 16'h1234, 1'b0, 16'h0000},
    {1'b0, 5'h14, 1'b1, 16'h0000, 1'b0, 16'h1234},
    {1'b1, 5'h14, 1'b0, 16'h00FF, 1'b1, 16'h0000},
    {1'b0, 5'h14, 1'b1, 16'h0000, 1'b0, 16'h1234},
    {1'b0, 5'h08, 1'b1, 16'h0000, 1'b1, 16'h0000},
    {1'b1, 5'h08, 1'b1, 16'h00FF, 1'b1, 16'h0000},
    {1'b0, 5'h08, 1'b0, 16'h0000, 1'b0, 16'h00A5},
    {1'b0, 5'h1E, 1'b0, 16'h0000, 1'b1, 16'h0000},
    {1'b0, 5'h09, 1'b0, 16'h0000, 1'b1, 16'h0000},
    {1'b0, 5'h15, 1'b1, 16'h0000, 1'b1, 16'h0000},
    {1'b1, 5'h16, 1'b1, 16'hBEEF, 1'b0, 16'h0000},
    {1'b0, 5'h16, 1'b1, 16'h0000, 1'b0, 16'hBEEF},
    {1'b1, 5'h18, 1'b0, 16'h003C, 1'b0, 16'h0000},
    {1'b0, 5'h18, 1'b0, 16'h0000, 1'b0, 16'h003C},
    {1'b1, 5'h1C, 1'b0, 16'h0001, 1'b0, 16'h0000},
    {1'b0, 5'h1C, 1'b0, 16'h0000, 1'b0, 16'h0001},
    {1'b1, 5'h0A, 1'b0, 16'h0009, 1'b0, 16'h0000},
    {1'b0, 5'h0A, 1'b0, 16'h0000, 1'b0, 16'h0009},
    {1'b0, 5'h10, 1'b0, 16'h0000, 1'b0, 16'h0000},
    {1'b0, 5'h00, 1'b1, 16'h0000, 1'b0, 16'h1111},
    {1'b0, 5'h02, 1'b1, 16'h0000, 1'b0, 16'h2222},
    {1'b0, 5'h04, 1'b1, 16'h0000, 1'b0, 16'h3333},
    {1'b0, 5'h06, 1'b1, 16'h0000, 1'b0, 16'h4444},
    {1'b1, 5'h00, 1'b1, 16'h9999, 1'b0, 16'h0000},
    {1'b0, 5'h00, 1'b1, 16'h0000, 1'b0, 16'h1111},
    {1'b0, 5'h06, 1'b0, 16'h0000, 1'b1, 16'h0000},
    {1'b1, 5'h0E, 1'b0, 16'h003F, 1'b0, 16'h0000},
    {1'b0, 5'h0E, 1'b0, 16'h0000, 1'b0, 16'h0000},
    {1'b1, 5'h0C, 1'b0, 16'h0064, 1'b0, 16'h0000},
    {1'b0, 5'h0C, 1'b0, 16'h0000, 1'b0, 16'h0064},
    {1'b0, 5'h10, 1'b1, 16'h0000, 1'b1, 16'h0000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one bus cycle, optionally with event pulses in the same cycle
  task automatic cyc(input logic wr, input logic [4:0] a, input logic h,
                     input logic [15:0] wd, input logic [5:0] ev,
                     output logic err, output logic [15:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_half = h; bus_wdata = wd;
    evt_set = ev;
    #1;
    err = bus_err; rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_req = 1'b0; bus_wr = 1'b0; evt_set = '0;
  endtask

  task automatic pulse(input logic [5:0] ev);
    @(negedge clk);
    evt_set = ev;
    @(posedge clk);
    #1;
    evt_set = '0;
  endtask

  function automatic logic [15:0] rd_byte_ref(input int unsigned k);
    return 16'(1) << k;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic e;
    logic [15:0] r;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq in reset", 16'(irq), 16'h0);
    check("R1 prescale in reset", 16'(cfg_prescale), 16'h0);
    check("R1 cmp_a in reset", cfg_cmp_a, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 5'h12, 1'b0, 16'h0, 6'h0, e, r);
    check("R1 enable after reset", r, 16'h0000);
    cyc(1'b0, 5'h0E, 1'b0, 16'h0, 6'h0, e, r);
    check("R1 pending after reset", r, 16'h0000);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][39], VEC[i][38:34], VEC[i][33], VEC[i][32:17], 6'h0, e, r);
      check($sformatf("table[%0d] err (R2 R3 R4 R5 R6 R7)", i), 16'(e), 16'(VEC[i][16]));
      check($sformatf("table[%0d] rdata (R2 R3 R4 R5 R6 R7)", i), r, VEC[i][15:0]);
    end
    #1;
    check("R2 cfg_prescale", 16'(cfg_prescale), 16'h00A5);
    check("R2 cfg_cmp_a little-endian", cfg_cmp_a, 16'h1234);
    check("R2 cfg_cmp_b", cfg_cmp_b, 16'hBEEF);
    check("R2 cfg_cmp_ctl", 16'(cfg_cmp_ctl), 16'h003C);
    check("R2 cfg_src_b", 16'(cfg_src_b), 16'h0001);
    check("R2 cfg_src_a", 16'(cfg_src_a), 16'h0000);
    check("R2 cfg_clk_sel", 16'(cfg_clk_sel), 16'h0009);
    check("R2 cfg_mode", 16'(cfg_mode), 16'h0064);

    // R6 R7: each event bit sets its own position, the clear removes it
    for (int k = 0; k < 6; k++) begin
      pulse(6'(rd_byte_ref(k)));
      cyc(1'b0, 5'h0E, 1'b0, 16'h0, 6'h0, e, r);
      check($sformatf("R6 pending bit %0d", k), r, rd_byte_ref(k));
      check("R9 irq with enable off", 16'(irq), 16'h0);
      cyc(1'b1, 5'h10, 1'b0, rd_byte_ref(k), 6'h0, e, r);
      cyc(1'b0, 5'h0E, 1'b0, 16'h0, 6'h0, e, r);
      check($sformatf("R7 cleared bit %0d", k), r, 16'h0000);
    end

    // R8: set and clear on the same bit, other bit cleared
    pulse(6'h10);
    cyc(1'b1, 5'h10, 1'b0, 16'h0012, 6'h02, e, r);
    cyc(1'b0, 5'h0E, 1'b0, 16'h0, 6'h0, e, r);
    check("R8 set wins over clear", r, 16'h0002);

    // R9: interrupt follows pending AND enable
    cyc(1'b1, 5'h12, 1'b0, 16'h0001, 6'h0, e, r);
    check("R9 irq unmatched enable", 16'(irq), 16'h0);
    cyc(1'b1, 5'h12, 1'b0, 16'h0022, 6'h0, e, r);
    check("R9 irq matched enable", 16'(irq), 16'h1);
    cyc(1'b1, 5'h10, 1'b0, 16'h0002, 6'h0, e, r);
    check("R9 irq after clear", 16'(irq), 16'h0);
    pulse(6'h20);
    check("R9 irq on enabled event", 16'(irq), 16'h1);
    cyc(1'b1, 5'h12, 1'b1, 16'h0000, 6'h0, e, r);
    check("R3 wide write to enable rejected", 16'(e), 16'h1);
    check("R3 irq kept after rejected write", 16'(irq), 16'h1);

    // R1: reset again with state present
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 irq low in reset", 16'(irq), 16'h0);
    check("R1 cmp_b cleared", cfg_cmp_b, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 5'h00, 1'b1, 16'h0, 6'h0, e, r);
    check("R1 live counter kept", r, 16'h1111);
    cyc(1'b0, 5'h0E, 1'b0, 16'h0, 6'h0, e, r);
    check("R1 pending cleared", r, 16'h0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule